// File: doc/BRIEF.md
# Single-Channel Dual-Address DMA Engine

This block is one self-requesting DMA channel. It copies data between two address ranges by issuing a read, holding the returned word in an internal register, and then writing that word to the destination. The channel needs no external trigger. While its enable input is high and no finished run is waiting to be acknowledged, it starts its next transfer unit by itself.

Before a run, the controlling logic presents a source address, a destination address, a 24-bit unit count and the mode fields, and pulses `cfg_load` while `bus_req` is low. A unit is 1, 2, 4 or 16 bytes long. A 16-byte unit is split into four read/write pairs of 4 bytes each.

The channel can use the bus in one of two ways. In cycle-stealing mode it asks for the bus again for every unit. In burst mode it keeps the bus until the run ends. It keeps two sticky flags, one at the half-way point and one at the end, and each flag has a maskable interrupt output. When reload is enabled, the count is restored for a following run.

The command side of the bus uses a valid/ready handshake. `mem_valid` rises with a command and stays high, with its address, direction, size and data unchanged, until `mem_ready` is seen high at a clock edge. Read data comes back on `mem_rvalid`, which has no back-pressure. There is only ever one read in flight, and the write that uses its data is always the next command.

Top module: `dma_chan`

## Requirements
- R1: A `cfg_load` pulse with `bus_req` low loads the source address, the destination address and the count (`cfg_count`). A count of 0 means 16,777,216 units: such a run does not end after a few units.
- R2: Every beat is a read of the current source address followed by a write to the current destination address. The write carries, on `mem_wdata`, the full 32-bit word returned for that read.
- R3: `cfg_unit` selects the unit size: 00 = 1 byte, 01 = 2 bytes and 10 = 4 bytes, each done as one beat with `mem_size` equal to the code. 11 = 16 bytes, done as four beats with `mem_size` = 10.
- R4: `cfg_src_mode` and `cfg_dst_mode` each select how that address moves after each beat: 00 keeps it fixed, 01 adds the beat size in bytes, 10 subtracts the beat size, and 11 keeps it fixed.
- R5: When `cfg_burst` = 0, `bus_req` is low in the cycle after the final write of each unit, and the channel waits for `bus_gnt` again before the next read.
- R6: When `cfg_burst` = 1 and the run continues with `enable` high, `bus_req` stays high and the next read is presented in the cycle after the final write of a unit.
- R7: A command holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` steady until it is accepted. A command is only presented while `bus_req` is high, and the first read of a tenure waits for `bus_gnt`.
- R8: `half_flag` sets when the unit after which the remaining count equals floor(N/2) completes, where N is the run length. It stays set until `flag_clr`. `irq_half` = `half_flag` AND `irq_half_en`.
- R9: `end_flag` sets when the last unit completes and stays set until `flag_clr`. While it is set, no bus request is made, even with `enable` high. `irq_end` = `end_flag` AND `irq_end_en`.
- R10: If `cfg_reload_en` = 1 when a run ends, the count is reloaded from `cfg_reload_count` (0 means 2^24) and the addresses carry on from where they stopped. The next run starts once the flags are cleared and `enable` is high.
- R11: If `enable` falls during a run, the unit in progress completes all of its beats and the channel then stops. Raising `enable` again resumes the run at the next address with the remaining count.
- R12: After reset, `bus_req`, `mem_valid`, both flags and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable, which is also the auto-request source |
| cfg_load | input | 1 | Load strobe for addresses and count, accepted while `bus_req` is low |
| cfg_src_addr | input | AW | Start source address |
| cfg_dst_addr | input | AW | Start destination address |
| cfg_count | input | CW | Number of units in the run, where 0 means 2^CW |
| cfg_reload_count | input | CW | Count restored at the end of a run when reload is enabled |
| cfg_reload_en | input | 1 | Reload enable |
| cfg_unit | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address update code |
| cfg_dst_mode | input | 2 | Destination address update code |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle-stealing |
| irq_half_en | input | 1 | Half-way interrupt mask |
| irq_end_en | input | 1 | End interrupt mask |
| flag_clr | input | 1 | Clears both sticky flags |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| mem_valid | output | 1 | Command valid |
| mem_ready | input | 1 | Command accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Command address |
| mem_size | output | 2 | Beat size: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| half_flag | output | 1 | Sticky half-way flag |
| end_flag | output | 1 | Sticky end-of-run flag |
| irq_half | output | 1 | Half-way interrupt |
| irq_end | output | 1 | End interrupt |

## Verification
Every command result comes at the clock edge where `mem_valid` and `mem_ready` are both high. The bench drives `mem_ready` at the falling edge and, in the same step, compares the command on the bus with the head of a queue of expected commands, so each comparison is tied to the edge that accepts it. The flags, and the drop or hold of `bus_req`, change at the edge that accepts the last write of a unit and are visible one cycle later. The model therefore updates its expected flags only after the comparison step and checks `bus_req` at the very next falling edge. `cfg_load` and `flag_clr` act at the edge that follows, so the model applies them at the same falling edge at which it sees them driven.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

  typedef enum logic [1:0] {
    UNIT_1B  = 2'b00,
    UNIT_2B  = 2'b01,
    UNIT_4B  = 2'b10,
    UNIT_16B = 2'b11
  } unit_e;

  typedef enum logic [1:0] {
    AM_FIXED = 2'b00,
    AM_INC   = 2'b01,
    AM_DEC   = 2'b10,
    AM_HOLD  = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD,
    ST_RWAIT,
    ST_WR
  } seq_e;

  // bytes moved by one bus beat for a unit code
  function automatic logic [2:0] unit_beat_bytes(input logic [1:0] u);
    case (u)
      UNIT_1B: return 3'd1;
      UNIT_2B: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // size code placed on the bus for each beat
  function automatic logic [1:0] unit_beat_code(input logic [1:0] u);
    return (u == UNIT_16B) ? UNIT_4B : u;
  endfunction

  // index of the final beat of one unit
  function automatic logic [1:0] unit_last_beat(input logic [1:0] u);
    return (u == UNIT_16B) ? 2'd3 : 2'd0;
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_chan_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic [2:0]    step_bytes,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] step_w;
  assign step_w = {{(AW-3){1'b0}}, step_bytes};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (adv) begin
      case (mode)
        AM_INC:  addr <= addr + step_w;
        AM_DEC:  addr <= addr - step_w;
        default: addr <= addr;
      endcase
    end
  end

endmodule

// File: rtl/dma_unit_ctr.sv
module dma_unit_ctr #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          unit_done,
  input  logic          reload_en,
  input  logic [CW-1:0] reload_cnt,
  input  logic          flag_clr,
  output logic          last_unit,
  output logic          half_flag,
  output logic          end_flag
);

  localparam int RW = CW + 1;
  localparam logic [RW-1:0] FULL = {1'b1, {CW{1'b0}}};
  localparam logic [RW-1:0] ONE  = {{CW{1'b0}}, 1'b1};

  logic [RW-1:0] rem;
  logic [RW-1:0] tot;
  logic [RW-1:0] rem_nx;

  // a programmed zero stands for the full 2^CW range
  function automatic logic [RW-1:0] widen(input logic [CW-1:0] v);
    return {(v == '0), v};
  endfunction

  assign rem_nx    = rem - ONE;
  assign last_unit = (rem == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= FULL;
      tot       <= FULL;
      half_flag <= 1'b0;
      end_flag  <= 1'b0;
    end else begin
      if (flag_clr) begin
        half_flag <= 1'b0;
        end_flag  <= 1'b0;
      end
      if (load) begin
        rem <= widen(load_cnt);
        tot <= widen(load_cnt);
      end else if (unit_done) begin
        if (rem_nx == (tot >> 1)) half_flag <= 1'b1;
        if (rem_nx == '0) begin
          end_flag <= 1'b1;
          if (reload_en) begin
            rem <= widen(reload_cnt);
            tot <= widen(reload_cnt);
          end else begin
            rem <= FULL;
            tot <= FULL;
          end
        end else begin
          rem <= rem_nx;
        end
      end
    end
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_chan_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          burst,
  input  logic          last_unit,
  input  logic [1:0]    unit_code,
  input  logic          bus_gnt,
  input  logic          mem_ready,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          bus_req,
  output logic          rd_cyc,
  output logic          wr_cyc,
  output logic          rd_acc,
  output logic          wr_acc,
  output logic          unit_done,
  output logic [DW-1:0] hold_data
);

  seq_e       st;
  seq_e       st_nx;
  logic [1:0] beat;
  logic       beat_last;

  assign beat_last = (beat == unit_last_beat(unit_code));
  assign rd_cyc    = (st == ST_RD);
  assign wr_cyc    = (st == ST_WR);
  assign rd_acc    = rd_cyc && mem_ready;
  assign wr_acc    = wr_cyc && mem_ready;
  assign unit_done = wr_acc && beat_last;
  assign bus_req   = (st != ST_IDLE);

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (go) st_nx = ST_ARB;
      ST_ARB: begin
        if (!go)         st_nx = ST_IDLE;
        else if (bus_gnt) st_nx = ST_RD;
      end
      ST_RD:    if (mem_ready) st_nx = ST_RWAIT;
      ST_RWAIT: if (mem_rvalid) st_nx = ST_WR;
      ST_WR: begin
        if (mem_ready) begin
          if (!beat_last)                      st_nx = ST_RD;
          else if (burst && go && !last_unit) st_nx = ST_RD;
          else                                 st_nx = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      beat      <= '0;
      hold_data <= '0;
    end else begin
      st <= st_nx;
      if (wr_acc) beat <= beat_last ? 2'd0 : beat + 2'd1;
      if (st == ST_RWAIT && mem_rvalid) hold_data <= mem_rdata;
    end
  end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_chan_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic [CW-1:0] cfg_reload_count,
  input  logic          cfg_reload_en,
  input  logic [1:0]    cfg_unit,
  input  logic [1:0]    cfg_src_mode,
  input  logic [1:0]    cfg_dst_mode,
  input  logic          cfg_burst,
  input  logic          irq_half_en,
  input  logic          irq_end_en,
  input  logic          flag_clr,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          half_flag,
  output logic          end_flag,
  output logic          irq_half,
  output logic          irq_end
);

  localparam int NSIDE = 2;  // 0 = source, 1 = destination

  logic          load_ok;
  logic          go;
  logic          last_unit;
  logic          rd_cyc, wr_cyc, rd_acc, wr_acc, unit_done;
  logic [2:0]    step_b;
  logic [AW-1:0] side_load [NSIDE];
  logic [AW-1:0] side_addr [NSIDE];
  logic          side_adv  [NSIDE];
  logic [1:0]    side_mode [NSIDE];

  assign load_ok = cfg_load && !bus_req;
  assign go      = enable && !end_flag;
  assign step_b  = unit_beat_bytes(cfg_unit);

  assign side_load[0] = cfg_src_addr;
  assign side_load[1] = cfg_dst_addr;
  assign side_adv[0]  = rd_acc;
  assign side_adv[1]  = wr_acc;
  assign side_mode[0] = cfg_src_mode;
  assign side_mode[1] = cfg_dst_mode;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dma_addr_step #(.AW(AW)) u_step (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load_ok),
      .load_addr  (side_load[g]),
      .adv        (side_adv[g]),
      .mode       (side_mode[g]),
      .step_bytes (step_b),
      .addr       (side_addr[g])
    );
  end

  dma_unit_ctr #(.CW(CW)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_ok),
    .load_cnt   (cfg_count),
    .unit_done  (unit_done),
    .reload_en  (cfg_reload_en),
    .reload_cnt (cfg_reload_count),
    .flag_clr   (flag_clr),
    .last_unit  (last_unit),
    .half_flag  (half_flag),
    .end_flag   (end_flag)
  );

  dma_seq #(.DW(DW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .burst      (cfg_burst),
    .last_unit  (last_unit),
    .unit_code  (cfg_unit),
    .bus_gnt    (bus_gnt),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .bus_req    (bus_req),
    .rd_cyc     (rd_cyc),
    .wr_cyc     (wr_cyc),
    .rd_acc     (rd_acc),
    .wr_acc     (wr_acc),
    .unit_done  (unit_done),
    .hold_data  (mem_wdata)
  );

  assign mem_valid = rd_cyc || wr_cyc;
  assign mem_we    = wr_cyc;
  assign mem_addr  = rd_cyc ? side_addr[0] : side_addr[1];
  assign mem_size  = unit_beat_code(cfg_unit);
  assign irq_half  = half_flag && irq_half_en;
  assign irq_end   = end_flag && irq_end_en;

endmodule

// File: rtl/dma_chan_sva.sv
module dma_chan_sva #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          half_flag,
  input logic          end_flag,
  input logic          flag_clr
);

  // R7: a stalled command keeps its fields
  p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R7: commands only while the bus is requested
  p_cmd_owned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> bus_req);

  // R8: half flag is sticky
  p_half_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    half_flag && !flag_clr |=> half_flag);

  // R9: end flag is sticky
  p_end_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag && !flag_clr |=> end_flag);

  // R9: no new request while the end flag stands
  p_end_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag && !flag_clr && !bus_req |=> !bus_req);

  // R9: a clear with the bus released empties the flag
  p_end_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !bus_req |=> !end_flag);

endmodule

bind dma_chan dma_chan_sva #(.AW(AW), .DW(DW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .half_flag (half_flag),
  .end_flag  (end_flag),
  .flag_clr  (flag_clr)
);

// File: tb/dma_chan_tb.sv
module dma_chan_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, cfg_load = 1'b0, cfg_reload_en = 1'b0, cfg_burst = 1'b0;
  logic [31:0] cfg_src_addr = '0, cfg_dst_addr = '0;
  logic [23:0] cfg_count = '0, cfg_reload_count = '0;
  logic [1:0]  cfg_unit = '0, cfg_src_mode = '0, cfg_dst_mode = '0;
  logic        irq_half_en = 1'b1, irq_end_en = 1'b1, flag_clr = 1'b0;
  logic        bus_req, bus_gnt = 1'b0;
  logic        mem_valid, mem_ready = 1'b0, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        half_flag, end_flag, irq_half, irq_end;

  dma_chan u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_load(cfg_load),
    .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
    .cfg_count(cfg_count), .cfg_reload_count(cfg_reload_count),
    .cfg_reload_en(cfg_reload_en), .cfg_unit(cfg_unit),
    .cfg_src_mode(cfg_src_mode), .cfg_dst_mode(cfg_dst_mode),
    .cfg_burst(cfg_burst), .irq_half_en(irq_half_en), .irq_end_en(irq_end_en),
    .flag_clr(flag_clr), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .half_flag(half_flag), .end_flag(end_flag), .irq_half(irq_half), .irq_end(irq_end)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic [1:0]  sz;
    logic        last;
  } xact_t;

  xact_t       expq[$];
  int          n_chk = 0, n_fail = 0;
  bit          finished = 0;
  logic [31:0] m_src = '0, m_dst = '0;
  int          exp_tot = 1 << 24, exp_done = 0, units = 0, hs_count = 0;
  bit          exp_half = 0, exp_end = 0;
  int          req_chk = 0, cyc = 0;
  bit          req_prev = 0, rd_pend = 0;
  int          rd_wait = 0;
  logic [31:0] rd_data = '0;

  function automatic logic [31:0] rdv(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  function automatic int ext(input logic [23:0] n);
    return (n == 0) ? (1 << 24) : int'(n);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] step_addr(input logic [31:0] a, input logic [1:0] mode, input int bb);
    case (mode)
      2'b01:   return a + bb;
      2'b10:   return a - bb;
      default: return a;
    endcase
  endfunction

  // expected commands of one unit, from R2 R3 R4
  task automatic gen_unit();
    int beats = (cfg_unit == 2'b11) ? 4 : 1;
    int bb    = (cfg_unit == 2'b11) ? 4 : (1 << cfg_unit);
    logic [1:0] sz = (cfg_unit == 2'b11) ? 2'b10 : cfg_unit;
    for (int b = 0; b < beats; b++) begin
      expq.push_back('{we: 1'b0, addr: m_src, data: 32'h0, sz: sz, last: 1'b0});
      expq.push_back('{we: 1'b1, addr: m_dst, data: rdv(m_src), sz: sz, last: (b == beats - 1)});
      m_src = step_addr(m_src, cfg_src_mode, bb);
      m_dst = step_addr(m_dst, cfg_dst_mode, bb);
    end
  endtask

  task automatic unit_complete();
    units++;
    exp_done++;
    if (exp_tot - exp_done == exp_tot / 2) exp_half = 1;
    if (exp_done == exp_tot) begin
      exp_end = 1;
      exp_tot = cfg_reload_en ? ext(cfg_reload_count) : (1 << 24);
      exp_done = 0;
      req_chk = 1;
    end else if (!cfg_burst) begin
      req_chk = 1;
    end else if (enable) begin
      req_chk = 2;
    end
  endtask

  task automatic do_hs();
    xact_t e;
    hs_count++;
    chk(bus_gnt, "R7 command without grant", 32'(bus_gnt), 32'd1);
    if (expq.size() == 0) gen_unit();
    e = expq.pop_front();
    chk(mem_we == e.we, "R2 read/write order", 32'(mem_we), 32'(e.we));
    chk(mem_addr == e.addr, e.we ? "R4 destination address" : "R4 source address", mem_addr, e.addr);
    chk(mem_size == e.sz, "R3 beat size", 32'(mem_size), 32'(e.sz));
    if (mem_we) begin
      chk(mem_wdata == e.data, "R2 write data", mem_wdata, e.data);
      if (e.last) unit_complete();
    end else begin
      rd_pend = 1;
      rd_wait = (hs_count % 2) + 1;
      rd_data = rdv(mem_addr);
    end
  endtask

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(half_flag == exp_half, "R8 half flag", 32'(half_flag), 32'(exp_half));
      chk(end_flag == exp_end, "R9 end flag", 32'(end_flag), 32'(exp_end));
      chk(irq_half == (exp_half && irq_half_en), "R8 half irq", 32'(irq_half), 32'(exp_half && irq_half_en));
      chk(irq_end == (exp_end && irq_end_en), "R9 end irq", 32'(irq_end), 32'(exp_end && irq_end_en));
      if (req_chk == 1) chk(!bus_req, "R5 bus released after unit", 32'(bus_req), 32'd0);
      if (req_chk == 2) chk(bus_req && mem_valid, "R6 burst keeps bus", 32'(bus_req && mem_valid), 32'd1);
      req_chk = 0;
      // drive bus responses for the coming edge
      cyc++;
      mem_ready = (cyc % 3) != 1;
      mem_rvalid = 1'b0;
      if (rd_pend) begin
        rd_wait--;
        if (rd_wait == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = rd_data;
          rd_pend = 0;
        end
      end
      bus_gnt = bus_req && req_prev;
      req_prev = bus_req;
      // events taking effect at the coming edge
      if (flag_clr) begin
        exp_half = 0;
        exp_end = 0;
      end
      if (cfg_load && !bus_req) begin
        m_src = cfg_src_addr;
        m_dst = cfg_dst_addr;
        exp_tot = ext(cfg_count);
        exp_done = 0;
      end
      if (mem_valid && mem_ready) do_hs();
    end
  end

  task automatic load(input logic [31:0] s, input logic [31:0] d, input logic [23:0] n,
                      input logic [1:0] u, input logic [1:0] sm, input logic [1:0] dm,
                      input bit bst, input bit rel, input logic [23:0] reln);
    @(posedge clk); #2;
    cfg_src_addr = s; cfg_dst_addr = d; cfg_count = n; cfg_unit = u;
    cfg_src_mode = sm; cfg_dst_mode = dm; cfg_burst = bst;
    cfg_reload_en = rel; cfg_reload_count = reln; cfg_load = 1'b1;
    @(posedge clk); #2;
    cfg_load = 1'b0;
  endtask

  task automatic set_en(input bit v);
    @(posedge clk); #2;
    enable = v;
  endtask

  task automatic clr_flags();
    @(posedge clk); #2;
    flag_clr = 1'b1;
    @(posedge clk); #2;
    flag_clr = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000 && !end_flag; i++) @(negedge clk);
  endtask

  task automatic wait_units(input int target);
    for (int i = 0; i < 5000 && units < target; i++) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int base, hs0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!bus_req && !mem_valid, "R12 reset bus outputs", 32'(bus_req || mem_valid), 32'd0);
    chk(!half_flag && !end_flag && !irq_half && !irq_end, "R12 reset flags",
        32'(half_flag || end_flag || irq_half || irq_end), 32'd0);
    rst_n = 1'b1;

    // 4-byte units, both incrementing, cycle-stealing
    base = units;
    load(32'h1000, 32'h2000, 24'd4, 2'b10, 2'b01, 2'b01, 0, 0, 24'd0);
    set_en(1);
    wait_end();
    chk(units - base == 4, "R1 loaded count moved", 32'(units - base), 32'd4);
    chk(expq.size() == 0, "R2 no partial unit", 32'(expq.size()), 32'd0);
    set_en(0);
    clr_flags();

    // 1-byte units, fixed source, burst, half irq masked
    irq_half_en = 1'b0;
    base = units;
    load(32'h3001, 32'h4003, 24'd3, 2'b00, 2'b00, 2'b01, 1, 0, 24'd0);
    set_en(1);
    wait_end();
    chk(units - base == 3, "R6 burst run length", 32'(units - base), 32'd3);
    set_en(0);
    clr_flags();
    irq_half_en = 1'b1;

    // 16-byte units, cycle-stealing
    base = units;
    load(32'h5000, 32'h6000, 24'd2, 2'b11, 2'b01, 2'b01, 0, 0, 24'd0);
    set_en(1);
    wait_end();
    chk(units - base == 2, "R3 sixteen-byte units", 32'(units - base), 32'd2);
    set_en(0);
    clr_flags();

    // 2-byte units, decrementing destination, burst, then sticky end
    base = units;
    load(32'h7000, 32'h8010, 24'd5, 2'b01, 2'b01, 2'b10, 1, 0, 24'd0);
    set_en(1);
    wait_end();
    hs0 = hs_count;
    repeat (20) @(negedge clk);
    chk(hs_count == hs0 && !bus_req, "R9 quiet while end flag set", 32'(hs_count - hs0), 32'd0);
    chk(units - base == 5, "R4 decrement run length", 32'(units - base), 32'd5);
    set_en(0);
    clr_flags();

    // reload: 3 units then 2 more after clear, hold-code source
    base = units;
    load(32'h9000, 32'hA000, 24'd3, 2'b10, 2'b11, 2'b01, 0, 1, 24'd2);
    set_en(1);
    wait_end();
    hs0 = hs_count;
    repeat (15) @(negedge clk);
    chk(hs_count == hs0, "R10 waits for flag clear", 32'(hs_count - hs0), 32'd0);
    clr_flags();
    wait_end();
    chk(units - base == 5, "R10 reloaded run", 32'(units - base), 32'd5);
    set_en(0);
    clr_flags();

    // enable drop mid-run
    base = units;
    load(32'hB000, 32'hC000, 24'd6, 2'b10, 2'b01, 2'b01, 0, 0, 24'd0);
    set_en(1);
    wait_units(base + 2);
    set_en(0);
    repeat (30) @(negedge clk);
    chk(expq.size() == 0 && !bus_req, "R11 halted on unit boundary", 32'(expq.size()), 32'd0);
    chk(units - base < 6, "R11 run not finished", 32'(units - base), 32'd5);
    set_en(1);
    wait_end();
    chk(units - base == 6, "R11 resumed run total", 32'(units - base), 32'd6);
    set_en(0);
    clr_flags();

    // zero count means 2^24 units
    base = units;
    load(32'hD000, 32'hE000, 24'd0, 2'b10, 2'b01, 2'b01, 1, 0, 24'd0);
    set_en(1);
    wait_units(base + 3);
    set_en(0);
    repeat (30) @(negedge clk);
    chk(units - base >= 3 && !end_flag, "R1 zero count keeps running", 32'(end_flag), 32'd0);

    summary();
  end

endmodule